// File: doc/BRIEF.md
# PCI Configuration Access Translator

This unit sits on the host side of a bridge and converts processor I/O port accesses into PCI configuration requests. Software first writes a 32-bit address word to the address port. It then reads or writes the data port. If the enable bit of the stored address word is set, the data-port access becomes a configuration access. The unit then does one of three things:
- It routes the access to one of the bridge's two internal functions.
- It issues an external type 0 or type 1 configuration cycle with the address-phase AD pattern already built.
- It rejects the access as a master abort.

Every other I/O access goes out unchanged as an ordinary I/O cycle.

Three streams use valid/ready handshakes: the incoming I/O request, the I/O response and the outgoing cycle request. Each stream holds its payload stable while valid is high and ready is low. Only one access is in flight at a time: `io_req_ready` is high only when the unit is idle, so back-pressure on the cycle or response stream stalls new requests. External completions arrive on a plain `cpl_valid` pulse. Internal functions are reached through a one-cycle select pulse, and their read data is sampled during that same cycle.

Top module: `cfg_access_xlate`

## Requirements
- R1: A 32-bit access with all byte enables at I/O address 0CF8h reads or writes the address register. Only bit 31 (enable) and bits [23:2] are stored, and the other bits read back 0. The register resets to 0, and a write responds with data 0.
- R2: An access to the data port 0CFCh while the enable bit is 0 is passed on as an ordinary I/O cycle. The same applies to a partial-byte-enable access to 0CF8h and to any other address. The cycle has kind 00, AD equal to the zero-extended I/O address, and command 0010 (read) or 0011 (write). A partial access to 0CF8h leaves the address register unchanged.
- R3: An enabled data-port access with bus [23:16]=0, device [15:11]=0 or 1 and function [10:8]=0 issues no external cycle. Instead it pulses `int_sel` for one cycle, with bit 0 for device 0 and bit 1 for device 1, and puts the register number [7:2] on `int_reg`. A read returns `int_rdata` as sampled during the pulse.
- R4: Bus 0, device 0 or 1 with a non-zero function number is a master abort. There is no select and no cycle, a read returns FFFFFFFFh, a write is dropped, and `cfg_abort` is high while that response is valid.
- R5: Bus 0 with device 2 to 20 issues a cycle of kind 01 (type 0) and command 1010 (read) or 1011 (write). Its AD has exactly one bit set among [31:11], at position 11+device, with the function on [10:8], the register on [7:2] and 00 on [1:0].
- R6: Bus 0 with device 21 to 31 is a master abort, handled as in R4.
- R7: A non-zero bus issues a cycle of kind 10 (type 1) and command 1010 or 1011. Its AD is {8'h00, bus, device, function, register, 2'b01}.
- R8: A completion with `cpl_abort` set makes a read return FFFFFFFFh and raises `cfg_abort` with the response. Otherwise a read returns `cpl_rdata` and a write responds with 0.
- R9: While `cyc_valid` or `io_rsp_valid` is high and its ready is low, the unit holds the payload stable. `io_req_ready` is low from acceptance until the response handshake.
- R10: The byte enables and write data of the access are forwarded on `cyc_be`/`cyc_wdata` for cycles and on `int_be`/`int_wdata` for internal selects, and the direction goes on `int_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | I/O request valid |
| io_req_ready | output | 1 | Unit idle and accepting |
| io_req_addr | input | 16 | I/O port address |
| io_req_be | input | 4 | Byte enables |
| io_req_wr | input | 1 | 1 = write, 0 = read |
| io_req_wdata | input | 32 | Write data |
| io_rsp_valid | output | 1 | Response valid |
| io_rsp_ready | input | 1 | Response accepted |
| io_rsp_rdata | output | 32 | Read data (0 for writes) |
| cyc_valid | output | 1 | Cycle request valid |
| cyc_ready | input | 1 | Cycle request accepted |
| cyc_kind | output | 2 | 00 I/O, 01 type 0, 10 type 1 |
| cyc_ad | output | 32 | Address-phase AD pattern |
| cyc_cmd | output | 4 | Bus command |
| cyc_be | output | 4 | Byte enables |
| cyc_wdata | output | 32 | Write data |
| cpl_valid | input | 1 | Completion pulse |
| cpl_abort | input | 1 | Completion ended in master abort |
| cpl_rdata | input | 32 | Completion read data |
| int_sel | output | 2 | One-hot internal function select pulse |
| int_reg | output | 6 | Internal register number |
| int_wr | output | 1 | Internal access is a write |
| int_be | output | 4 | Internal byte enables |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, sampled during select |
| cfg_abort | output | 1 | Response belongs to an aborted access |

## Verification
A corrupted address register shows up one access later: the next data-port access comes out with the wrong cycle kind, an AD pattern with a missing or doubled select bit, or an unexpected internal select. A wrong state in the control sequencer shows up within a cycle or two: a response appears with no completion behind it, a cycle request stalls, or a second request is accepted while one is still open. Each stimulus is therefore followed by comparing every emitted cycle and select against an expected queue, and by checking that the response data and the abort flag match the access that produced them.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DW = 32;
  localparam int AW = 16;

  typedef enum logic [1:0] {
    KIND_IO = 2'b00,
    KIND_T0 = 2'b01,
    KIND_T1 = 2'b10
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ACT_AREG  = 2'b00,
    ACT_INT   = 2'b01,
    ACT_ABORT = 2'b10,
    ACT_CYC   = 2'b11
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INT  = 3'd1,
    ST_CYC  = 3'd2,
    ST_CPL  = 3'd3,
    ST_RSP  = 3'd4
  } state_e;
endpackage

// File: rtl/cfgx_areg.sv
module cfgx_areg #(
  parameter int          W    = 32,
  parameter logic [31:0] MASK = 32'h80FF_FFFC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MASK[W-1:0];
  end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter logic [AW-1:0] PORT_ADDR  = 16'h0CF8,
  parameter logic [AW-1:0] PORT_DATA  = 16'h0CFC,
  parameter int            IDSEL_BASE = 11
) (
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be,
  input  logic          wr,
  input  logic [DW-1:0] areg,
  output act_e          act,
  output cyc_kind_e     kind,
  output logic [DW-1:0] ad,
  output logic [3:0]    cmd,
  output logic [1:0]    isel
);
  localparam int NSEL = DW - IDSEL_BASE;

  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic [5:0] rnum;
  logic [NSEL-1:0] idsel;

  assign bus  = areg[23:16];
  assign dev  = areg[15:11];
  assign fn   = areg[10:8];
  assign rnum = areg[7:2];

  for (genvar i = 0; i < NSEL; i++) begin : g_idsel
    assign idsel[i] = (dev == 5'(i));
  end

  always_comb begin
    act  = ACT_CYC;
    kind = KIND_IO;
    ad   = {{(DW-AW){1'b0}}, addr};
    isel = 2'b00;
    if (addr == PORT_ADDR && be == 4'hF) begin
      act = ACT_AREG;
    end else if (addr == PORT_DATA && areg[31]) begin
      if (bus == 8'h00 && dev < 5'd2) begin
        act  = (fn != 3'd0) ? ACT_ABORT : ACT_INT;
        isel = dev[0] ? 2'b10 : 2'b01;
      end else if (bus == 8'h00) begin
        act  = (idsel == '0) ? ACT_ABORT : ACT_CYC;
        kind = KIND_T0;
        ad   = {idsel, fn, rnum, 2'b00};
      end else begin
        kind = KIND_T1;
        ad   = {8'h00, bus, dev, fn, rnum, 2'b01};
      end
    end
    cmd = {kind != KIND_IO, 1'b0, 1'b1, wr};
  end
endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
  import cfgx_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR  = 16'h0CF8,
  parameter logic [15:0] PORT_DATA  = 16'h0CFC,
  parameter int          IDSEL_BASE = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req_valid,
  output logic        io_req_ready,
  input  logic [15:0] io_req_addr,
  input  logic [3:0]  io_req_be,
  input  logic        io_req_wr,
  input  logic [31:0] io_req_wdata,
  output logic        io_rsp_valid,
  input  logic        io_rsp_ready,
  output logic [31:0] io_rsp_rdata,
  output logic        cyc_valid,
  input  logic        cyc_ready,
  output logic [1:0]  cyc_kind,
  output logic [31:0] cyc_ad,
  output logic [3:0]  cyc_cmd,
  output logic [3:0]  cyc_be,
  output logic [31:0] cyc_wdata,
  input  logic        cpl_valid,
  input  logic        cpl_abort,
  input  logic [31:0] cpl_rdata,
  output logic [1:0]  int_sel,
  output logic [5:0]  int_reg,
  output logic        int_wr,
  output logic [3:0]  int_be,
  output logic [31:0] int_wdata,
  input  logic [31:0] int_rdata,
  output logic        cfg_abort
);
  localparam logic [31:0] ALL_ONES = '1;

  state_e        st;
  logic [31:0]   areg_q;
  logic          areg_we;
  act_e          d_act;
  cyc_kind_e     d_kind;
  logic [31:0]   d_ad;
  logic [3:0]    d_cmd;
  logic [1:0]    d_isel;
  logic          accept;

  logic          wr_q;
  logic [3:0]    be_q;
  logic [31:0]   wdata_q;
  cyc_kind_e     kind_q;
  logic [31:0]   ad_q;
  logic [3:0]    cmd_q;
  logic [1:0]    isel_q;
  logic [5:0]    reg_q;
  logic [31:0]   rdata_q;
  logic          abort_q;

  cfgx_decode #(
    .PORT_ADDR (PORT_ADDR),
    .PORT_DATA (PORT_DATA),
    .IDSEL_BASE(IDSEL_BASE)
  ) u_dec (
    .addr(io_req_addr),
    .be  (io_req_be),
    .wr  (io_req_wr),
    .areg(areg_q),
    .act (d_act),
    .kind(d_kind),
    .ad  (d_ad),
    .cmd (d_cmd),
    .isel(d_isel)
  );

  assign accept  = io_req_valid && (st == ST_IDLE);
  assign areg_we = accept && (d_act == ACT_AREG) && io_req_wr;

  cfgx_areg #(.W(32), .MASK(32'h80FF_FFFC)) u_areg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (areg_we),
    .wdata(io_req_wdata),
    .q    (areg_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      kind_q  <= KIND_IO;
      ad_q    <= '0;
      cmd_q   <= '0;
      isel_q  <= '0;
      reg_q   <= '0;
      rdata_q <= '0;
      abort_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          wr_q    <= io_req_wr;
          be_q    <= io_req_be;
          wdata_q <= io_req_wdata;
          kind_q  <= d_kind;
          ad_q    <= d_ad;
          cmd_q   <= d_cmd;
          isel_q  <= d_isel;
          reg_q   <= areg_q[7:2];
          abort_q <= 1'b0;
          unique case (d_act)
            ACT_AREG: begin
              rdata_q <= io_req_wr ? '0 : areg_q;
              st      <= ST_RSP;
            end
            ACT_ABORT: begin
              rdata_q <= io_req_wr ? '0 : ALL_ONES;
              abort_q <= 1'b1;
              st      <= ST_RSP;
            end
            ACT_INT: st <= ST_INT;
            default: st <= ST_CYC;
          endcase
        end
        ST_INT: begin
          rdata_q <= wr_q ? '0 : int_rdata;
          st      <= ST_RSP;
        end
        ST_CYC: if (cyc_ready) st <= ST_CPL;
        ST_CPL: if (cpl_valid) begin
          rdata_q <= wr_q ? '0 : (cpl_abort ? ALL_ONES : cpl_rdata);
          abort_q <= cpl_abort;
          st      <= ST_RSP;
        end
        ST_RSP: if (io_rsp_ready) begin
          abort_q <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign io_req_ready = (st == ST_IDLE);
  assign io_rsp_valid = (st == ST_RSP);
  assign io_rsp_rdata = rdata_q;
  assign cfg_abort    = (st == ST_RSP) && abort_q;

  assign cyc_valid = (st == ST_CYC);
  assign cyc_kind  = kind_q;
  assign cyc_ad    = ad_q;
  assign cyc_cmd   = cmd_q;
  assign cyc_be    = be_q;
  assign cyc_wdata = wdata_q;

  assign int_sel   = (st == ST_INT) ? isel_q : 2'b00;
  assign int_reg   = reg_q;
  assign int_wr    = wr_q;
  assign int_be    = be_q;
  assign int_wdata = wdata_q;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_req_ready,
  input logic        io_rsp_valid,
  input logic        io_rsp_ready,
  input logic [31:0] io_rsp_rdata,
  input logic        cyc_valid,
  input logic        cyc_ready,
  input logic [1:0]  cyc_kind,
  input logic [31:0] cyc_ad,
  input logic [3:0]  cyc_cmd,
  input logic [1:0]  int_sel,
  input logic        cfg_abort
);
  assert_cyc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_ad) && $stable(cyc_cmd) && $stable(cyc_kind)));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid && !io_rsp_ready) |=> (io_rsp_valid && $stable(io_rsp_rdata) && $stable(cfg_abort)));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_ready |-> (!io_rsp_valid && !cyc_valid && int_sel == 2'b00));

  assert_type0_idsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 2'b01) |-> ($onehot(cyc_ad[31:11]) && cyc_ad[1:0] == 2'b00 && cyc_cmd[3]));

  assert_type1_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 2'b10) |-> (cyc_ad[1:0] == 2'b01 && cyc_ad[31:24] == 8'h00 && cyc_ad[23:16] != 8'h00));

  assert_int_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_sel) && !(int_sel != 2'b00 && cyc_valid));

  assert_int_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sel != 2'b00) |=> (int_sel == 2'b00));

  assert_abort_only_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_abort |-> io_rsp_valid);
endmodule

bind cfg_access_xlate cfgx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_req_ready(io_req_ready),
  .io_rsp_valid(io_rsp_valid),
  .io_rsp_ready(io_rsp_ready),
  .io_rsp_rdata(io_rsp_rdata),
  .cyc_valid   (cyc_valid),
  .cyc_ready   (cyc_ready),
  .cyc_kind    (cyc_kind),
  .cyc_ad      (cyc_ad),
  .cyc_cmd     (cyc_cmd),
  .int_sel     (int_sel),
  .cfg_abort   (cfg_abort)
);

// File: tb/cfg_access_xlate_test.sv
module cfg_access_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req_valid = 1'b0;
  logic        io_req_ready;
  logic [15:0] io_req_addr = '0;
  logic [3:0]  io_req_be = '0;
  logic        io_req_wr = 1'b0;
  logic [31:0] io_req_wdata = '0;
  logic        io_rsp_valid;
  logic        io_rsp_ready = 1'b1;
  logic [31:0] io_rsp_rdata;
  logic        cyc_valid;
  logic        cyc_ready = 1'b0;
  logic [1:0]  cyc_kind;
  logic [31:0] cyc_ad;
  logic [3:0]  cyc_cmd;
  logic [3:0]  cyc_be;
  logic [31:0] cyc_wdata;
  logic        cpl_valid = 1'b0;
  logic        cpl_abort = 1'b0;
  logic [31:0] cpl_rdata = '0;
  logic [1:0]  int_sel;
  logic [5:0]  int_reg;
  logic        int_wr;
  logic [3:0]  int_be;
  logic [31:0] int_wdata;
  logic [31:0] int_rdata;
  logic        cfg_abort;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign int_rdata = {14'h0, int_sel, 10'h0, int_reg};

  cfg_access_xlate uut (.*);

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] ad;
    logic [3:0]  cmd;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        cab;
    logic [31:0] cdata;
  } cyc_item_t;

  typedef struct {
    logic [1:0]  sel;
    logic [5:0]  rn;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
  } int_item_t;

  cyc_item_t cyc_q[$];
  int_item_t int_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] t0_ad(input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] rn);
    logic [31:0] v;
    v = 32'h1 << (11 + int'(dev));
    v = v | (32'(fn) << 8) | (32'(rn) << 2);
    return v;
  endfunction

  task automatic push_cyc(input logic [1:0] k, input logic [31:0] ad, input logic [3:0] cmd,
                          input logic [3:0] be, input logic [31:0] wd, input logic cab, input logic [31:0] cd);
    cyc_item_t it;
    it.kind = k; it.ad = ad; it.cmd = cmd; it.be = be; it.wd = wd; it.cab = cab; it.cdata = cd;
    cyc_q.push_back(it);
  endtask

  task automatic push_int(input logic [1:0] sel, input logic [5:0] rn, input logic wr,
                          input logic [3:0] be, input logic [31:0] wd);
    int_item_t it;
    it.sel = sel; it.rn = rn; it.wr = wr; it.be = be; it.wd = wd;
    int_q.push_back(it);
  endtask

  task automatic io_access(input logic [15:0] a, input logic [3:0] be, input logic wr, input logic [31:0] wd,
                           input logic [31:0] exp_d, input logic exp_ab, input string req, input int hold = 0);
    logic [31:0] first;
    @(negedge clk);
    io_req_addr = a; io_req_be = be; io_req_wr = wr; io_req_wdata = wd; io_req_valid = 1'b1;
    if (hold > 0) io_rsp_ready = 1'b0;
    while (!io_req_ready) @(negedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
    check(!io_req_ready, {req, " ready low while busy (R9)"}, 32'(io_req_ready), 0);
    while (!io_rsp_valid) @(negedge clk);
    first = io_rsp_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(io_rsp_valid && io_rsp_rdata == first, {req, " response held (R9)"}, io_rsp_rdata, first);
    end
    check(io_rsp_rdata == exp_d, {req, " data"}, io_rsp_rdata, exp_d);
    check(cfg_abort == exp_ab, {req, " abort flag"}, 32'(cfg_abort), 32'(exp_ab));
    check(cyc_q.size() == 0 && int_q.size() == 0, {req, " expected cycle/select missing"},
          32'(cyc_q.size() + int_q.size()), 0);
    io_rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  // Cycle monitor: alternates back-pressure, compares, returns a completion.
  initial begin
    bit stall = 1'b0;
    cyc_item_t e;
    forever begin
      @(negedge clk);
      if (cyc_valid) begin
        stall = !stall;
        cyc_ready = !stall;
        if (cyc_ready) begin
          if (cyc_q.size() == 0) begin
            check(1'b0, "unexpected external cycle (R3/R4/R6)", cyc_ad, 0);
            e.cab = 1'b0; e.cdata = '0;
          end else begin
            e = cyc_q.pop_front();
            check(cyc_kind == e.kind, "cycle kind (R2/R5/R7)", 32'(cyc_kind), 32'(e.kind));
            check(cyc_ad == e.ad, "cycle AD (R2/R5/R7)", cyc_ad, e.ad);
            check(cyc_cmd == e.cmd, "cycle command (R2/R5/R7)", 32'(cyc_cmd), 32'(e.cmd));
            check(cyc_be == e.be && cyc_wdata == e.wd, "cycle be/data (R10)", cyc_wdata, e.wd);
          end
          @(negedge clk);
          cyc_ready = 1'b0;
          @(negedge clk);
          cpl_valid = 1'b1; cpl_abort = e.cab; cpl_rdata = e.cdata;
          @(negedge clk);
          cpl_valid = 1'b0; cpl_abort = 1'b0;
        end
      end
    end
  end

  // Internal select monitor.
  initial begin
    int_item_t e;
    forever begin
      @(negedge clk);
      if (int_sel != 2'b00) begin
        if (int_q.size() == 0) begin
          check(1'b0, "unexpected internal select (R4)", 32'(int_sel), 0);
        end else begin
          e = int_q.pop_front();
          check(int_sel == e.sel, "internal select (R3)", 32'(int_sel), 32'(e.sel));
          check(int_reg == e.rn, "internal register (R3)", 32'(int_reg), 32'(e.rn));
          check(int_wr == e.wr && int_be == e.be && int_wdata == e.wd, "internal be/data (R10)",
                int_wdata, e.wd);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(io_req_ready && !io_rsp_valid && !cyc_valid && int_sel == 0 && !cfg_abort,
          "reset outputs (R1)", 32'({io_req_ready, io_rsp_valid, cyc_valid}), 32'b100);
    io_access(16'h0CF8, 4'hF, 1'b0, '0, 32'h0, 1'b0, "R1 address reg reset value");
    io_access(16'h0CF8, 4'hF, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, "R1 write all ones");
    io_access(16'h0CF8, 4'hF, 1'b0, '0, 32'h80FF_FFFC, 1'b0, "R1 reserved bits read zero");

    // R2 enable clear -> plain I/O
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h0001_0808, 32'h0, 1'b0, "R1 write disabled addr");
    push_cyc(2'b00, 32'h0000_0CFC, 4'b0010, 4'hF, 32'h0, 1'b0, 32'h1234_5678);
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'h1234_5678, 1'b0, "R2 data port disabled");
    push_cyc(2'b00, 32'h0000_0CF8, 4'b0011, 4'h3, 32'hDEAD_BEEF, 1'b0, 32'h0);
    io_access(16'h0CF8, 4'h3, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0, "R2 partial address write");
    io_access(16'h0CF8, 4'hF, 1'b0, '0, 32'h0001_0808, 1'b0, "R2 address reg unchanged");
    push_cyc(2'b00, 32'h0000_0080, 4'b0010, 4'h1, 32'h0, 1'b0, 32'h0000_00A5);
    io_access(16'h0080, 4'h1, 1'b0, '0, 32'h0000_00A5, 1'b0, "R2 other port");

    // R3 internal functions
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_0010, 32'h0, 1'b0, "R3 setup dev0");
    push_int(2'b01, 6'd4, 1'b0, 4'hF, 32'h0);
    io_access(16'h0CFC, 4'hF, 1'b0, '0, {14'h0, 2'b01, 10'h0, 6'd4}, 1'b0, "R3 dev0 read");
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_08FC, 32'h0, 1'b0, "R3 setup dev1");
    push_int(2'b10, 6'h3F, 1'b1, 4'h5, 32'hCAFE_0001);
    io_access(16'h0CFC, 4'h5, 1'b1, 32'hCAFE_0001, 32'h0, 1'b0, "R10 dev1 write");

    // R4 non-zero function on internal device
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_0900, 32'h0, 1'b0, "R4 setup");
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'hFFFF_FFFF, 1'b1, "R4 abort read");
    io_access(16'h0CFC, 4'hF, 1'b1, 32'h5555_5555, 32'h0, 1'b1, "R4 abort write");

    // R5 type 0
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_1314, 32'h0, 1'b0, "R5 setup dev2");
    push_cyc(2'b01, t0_ad(5'd2, 3'd3, 6'd5), 4'b1010, 4'hF, 32'h0, 1'b0, 32'h0BAD_F00D);
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'h0BAD_F00D, 1'b0, "R5 dev2 read", 3);
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_A000, 32'h0, 1'b0, "R5 setup dev20");
    push_cyc(2'b01, 32'h8000_0000, 4'b1011, 4'hC, 32'h1111_2222, 1'b0, 32'h0);
    io_access(16'h0CFC, 4'hC, 1'b1, 32'h1111_2222, 32'h0, 1'b0, "R5 dev20 write");

    // R6 device beyond IDSEL range
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_A800, 32'h0, 1'b0, "R6 setup dev21");
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'hFFFF_FFFF, 1'b1, "R6 dev21 abort");
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h8000_FF00, 32'h0, 1'b0, "R6 setup dev31");
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'hFFFF_FFFF, 1'b1, "R6 dev31 abort");

    // R7 type 1
    io_access(16'h0CF8, 4'hF, 1'b1, 32'h80AB_5A7C, 32'h0, 1'b0, "R7 setup");
    push_cyc(2'b10, {8'h00, 8'hAB, 5'd11, 3'd2, 6'd31, 2'b01}, 4'b1010, 4'hF, 32'h0, 1'b0, 32'h7777_0000);
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'h7777_0000, 1'b0, "R7 type1 read");

    // R8 completion abort
    push_cyc(2'b10, {8'h00, 8'hAB, 5'd11, 3'd2, 6'd31, 2'b01}, 4'b1010, 4'hF, 32'h0, 1'b1, 32'h0);
    io_access(16'h0CFC, 4'hF, 1'b0, '0, 32'hFFFF_FFFF, 1'b1, "R8 aborted completion", 2);
    push_cyc(2'b10, {8'h00, 8'hAB, 5'd11, 3'd2, 6'd31, 2'b01}, 4'b1011, 4'hF, 32'h9, 1'b1, 32'h0);
    io_access(16'h0CFC, 4'hF, 1'b1, 32'h9, 32'h0, 1'b1, "R8 aborted write");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule